// File: doc/BRIEF.md
# Code-Locality Thread Migration Controller

This block decides when a running hardware thread should leave its core and which core it should go to, so that threads running the same code reuse instructions that another core has already brought into its L1 instruction cache. A thread that arrives is queued and then placed on an idle core. It keeps that core until the core has taken one cache's worth of line-fill misses on its behalf. At that point the block picks a destination core in the same socket and issues a migrate command. When the transfer ends, the core the thread left is given to the next waiting thread. That thread then runs through code that is already cached.

Two signatures drive the choice of destination. Each core keeps a content signature, which is a small Bloom-style bit vector that collects the hashed line address of every miss the core has taken. Each resident thread keeps a run signature, which collects the hashed lines it has missed on since it arrived. The destination is the idle core in the thread's socket whose content signature shares the most set bits with the thread's run signature. If no such core is free, the thread stays where it is and its fill count starts again. Only one migration is in flight at a time. Its source and destination cores are locked from the decision until the transfer window closes.

Top module: `tmc_migrate_ctl`

## Requirements
- R1: After a synchronous reset, `mig_valid` and `adm_valid` are low and `arr_ready` is high.
- R2: Arriving threads wait in a first-in first-out queue. The head is admitted onto the lowest-index core that is neither occupied nor locked. `adm_valid`, `adm_core` and `adm_tid` appear one clock after the clock edge that accepted the arrival.
- R3: A core raises a migration decision once it has counted `FILL_LINES` miss events since its thread arrived. `mig_valid` rises in the cycle after the edge that sampled the miss reaching that count, and never earlier.
- R4: Only idle, unlocked cores in the source's socket are candidates. A socket is a group of `CPS` consecutive core indices. The chosen core has the highest popcount of (run signature AND content signature). A line address maps to signature bit h, where bit i of h is the XOR of every line bit whose index modulo log2(`SIG_W`) equals i. A line below `SIG_W` therefore sets bit number equal to its own value.
- R5: When candidate scores tie, including the case where every score is zero, the lowest-index candidate is chosen.
- R6: If no candidate exists, no command is issued and the thread's fill count restarts. A further `FILL_LINES` misses are needed before the next decision.
- R7: While `mig_valid` is high and `mig_ready` is low, `mig_valid`, `mig_src`, `mig_dst` and `mig_tid` hold their values.
- R8: After the handshake, the block waits `XFER_CYC` cycles before it issues another command. During that time neither locked core receives an admission. If the queue is non-empty, its head is admitted onto the vacated source core, with `adm_valid` appearing exactly `XFER_CYC` cycles after the handshake edge.
- R9: A `fin` pulse on an unlocked occupied core frees it, so a queued thread can be admitted there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arr_valid | input | 1 | A new thread is offered |
| arr_tid | input | TID_W | Identifier of the offered thread |
| arr_ready | output | 1 | Queue can accept a thread |
| miss_valid | input | N_CORES | Per-core line-fill miss event |
| miss_line | input | N_CORES*LINE_W | Per-core missed line address, core c in slice c |
| fin | input | N_CORES | Per-core pulse: the resident thread has exited |
| mig_valid | output | 1 | Migrate command valid |
| mig_ready | input | 1 | Consumer accepts the migrate command |
| mig_src | output | clog2(N_CORES) | Core being left |
| mig_dst | output | clog2(N_CORES) | Core receiving the thread |
| mig_tid | output | TID_W | Thread being moved |
| adm_valid | output | 1 | One-cycle pulse: a queued thread was placed on a core |
| adm_core | output | clog2(N_CORES) | Core that received the queued thread |
| adm_tid | output | TID_W | Identifier of the admitted thread |

## Verification
Four properties are checked on every cycle:
- a pending command holds steady until it is accepted;
- source and destination are distinct and share a socket;
- no second command appears inside the transfer window, and the locked destination receives no admission in that window;
- an admission only happens while arrivals are outstanding.

Some behaviour only the bench scenarios can show:
- the choice of the best-matching core over a lower-index rival;
- the tie rule;
- the exact cycle on which the fill count triggers;
- the restart of the fill count when no candidate is free;
- the handover of the vacated core at the exact end of the window.

// File: rtl/tmc_pkg.sv
package tmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2
  } tmc_state_e;
endpackage

// File: rtl/tmc_fifo.sv
module tmc_fifo #(
  parameter int W     = 4,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));
  assign dout  = mem[rd_ptr];

  // storage array: write-only clocked process, no reset
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/tmc_core_track.sv
module tmc_core_track #(
  parameter int LINE_W     = 26,
  parameter int SIG_W      = 16,
  parameter int TID_W      = 4,
  parameter int FILL_LINES = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miss_v,
  input  logic [LINE_W-1:0] miss_line,
  input  logic              lock,
  input  logic              fin,
  input  logic              start,
  input  logic [TID_W-1:0]  start_tid,
  input  logic              restart,
  input  logic              vacate,
  output logic              occ,
  output logic [TID_W-1:0]  tid,
  output logic              full,
  output logic [SIG_W-1:0]  run_sig,
  output logic [SIG_W-1:0]  cont_sig
);
  localparam int IDX_W = $clog2(SIG_W);
  localparam int CNT_W = $clog2(FILL_LINES + 1);

  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic [SIG_W-1:0] bit_v;

  // fold the line address onto a signature bit index
  always_comb begin
    idx = '0;
    for (int i = 0; i < LINE_W; i++) idx[i % IDX_W] = idx[i % IDX_W] ^ miss_line[i];
  end
  assign bit_v = SIG_W'(1) << idx;

  assign full = occ && !lock && !fin && (cnt == CNT_W'(FILL_LINES));

  always_ff @(posedge clk) begin
    if (rst) begin
      occ      <= 1'b0;
      tid      <= '0;
      cnt      <= '0;
      run_sig  <= '0;
      cont_sig <= '0;
    end else begin
      if (miss_v && !lock) cont_sig <= cont_sig | bit_v;
      if (start) begin
        occ     <= 1'b1;
        tid     <= start_tid;
        cnt     <= '0;
        run_sig <= '0;
      end else if (restart) begin
        cnt     <= '0;
        run_sig <= '0;
      end else begin
        if ((fin && !lock) || vacate) occ <= 1'b0;
        if (miss_v && occ && !lock) begin
          if (cnt != CNT_W'(FILL_LINES)) cnt <= cnt + 1'b1;
          run_sig <= run_sig | bit_v;
        end
      end
    end
  end
endmodule

// File: rtl/tmc_dest_pick.sv
module tmc_dest_pick #(
  parameter int N_CORES = 4,
  parameter int CPS     = 2,
  parameter int SIG_W   = 16
) (
  input  logic [$clog2(N_CORES)-1:0] src,
  input  logic [SIG_W-1:0]           want,
  input  logic [N_CORES*SIG_W-1:0]   cont,
  input  logic [N_CORES-1:0]         avail,
  output logic                       found,
  output logic [$clog2(N_CORES)-1:0] dst
);
  localparam int CORE_W  = $clog2(N_CORES);
  localparam int SCORE_W = $clog2(SIG_W + 1);

  logic [SCORE_W-1:0] score [N_CORES];
  logic [N_CORES-1:0] elig;
  logic [SCORE_W-1:0] best;

  for (genvar c = 0; c < N_CORES; c++) begin : g_score
    logic [SCORE_W-1:0] sc;
    always_comb begin
      sc = '0;
      for (int b = 0; b < SIG_W; b++) sc = sc + SCORE_W'(want[b] & cont[c*SIG_W + b]);
    end
    assign score[c] = sc;
    assign elig[c]  = avail[c] && (c != int'(src)) && ((c / CPS) == (int'(src) / CPS));
  end

  // strict compare keeps the lowest index on ties
  always_comb begin
    found = 1'b0;
    dst   = '0;
    best  = '0;
    for (int c = 0; c < N_CORES; c++) begin
      if (elig[c] && (!found || score[c] > best)) begin
        found = 1'b1;
        best  = score[c];
        dst   = CORE_W'(c);
      end
    end
  end
endmodule

// File: rtl/tmc_migrate_ctl.sv
module tmc_migrate_ctl
  import tmc_pkg::*;
#(
  parameter int N_CORES    = 4,
  parameter int CPS        = 2,
  parameter int TID_W      = 4,
  parameter int LINE_W     = 26,
  parameter int SIG_W      = 16,
  parameter int FILL_LINES = 512,
  parameter int XFER_CYC   = 90,
  parameter int QDEPTH     = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        arr_valid,
  input  logic [TID_W-1:0]            arr_tid,
  output logic                        arr_ready,
  input  logic [N_CORES-1:0]          miss_valid,
  input  logic [N_CORES*LINE_W-1:0]   miss_line,
  input  logic [N_CORES-1:0]          fin,
  output logic                        mig_valid,
  input  logic                        mig_ready,
  output logic [$clog2(N_CORES)-1:0]  mig_src,
  output logic [$clog2(N_CORES)-1:0]  mig_dst,
  output logic [TID_W-1:0]            mig_tid,
  output logic                        adm_valid,
  output logic [$clog2(N_CORES)-1:0]  adm_core,
  output logic [TID_W-1:0]            adm_tid
);
  localparam int CORE_W = $clog2(N_CORES);
  localparam int TMR_W  = $clog2(XFER_CYC + 1);

  tmc_state_e st;
  logic [TMR_W-1:0] timer;
  logic             lock_on;

  logic [N_CORES-1:0]             occ, full, lock, start, restart, vacate;
  logic [N_CORES-1:0][TID_W-1:0]  tid_v, start_tid;
  logic [N_CORES-1:0][SIG_W-1:0]  run_sig;
  logic [N_CORES*SIG_W-1:0]       cont_flat;

  logic             q_push, q_pop, q_empty, q_full;
  logic [TID_W-1:0] q_dout;

  logic              has_full, adm_ok, d_found, decide, done, adm_fire;
  logic [CORE_W-1:0] src_c, adm_pick, d_dst, adm_core_c;
  logic [SIG_W-1:0]  want;

  assign arr_ready = !q_full;
  assign q_push    = arr_valid && !q_full;

  tmc_fifo #(.W(TID_W), .DEPTH(QDEPTH)) u_queue (
    .clk(clk), .rst(rst), .push(q_push), .din(arr_tid), .pop(q_pop),
    .dout(q_dout), .empty(q_empty), .full(q_full)
  );

  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    assign lock[c] = lock_on && ((CORE_W'(c) == mig_src) || (CORE_W'(c) == mig_dst));
    assign start_tid[c] = (done && CORE_W'(c) == mig_dst) ? mig_tid : q_dout;
    tmc_core_track #(
      .LINE_W(LINE_W), .SIG_W(SIG_W), .TID_W(TID_W), .FILL_LINES(FILL_LINES)
    ) u_trk (
      .clk(clk), .rst(rst),
      .miss_v(miss_valid[c]), .miss_line(miss_line[c*LINE_W +: LINE_W]),
      .lock(lock[c]), .fin(fin[c]),
      .start(start[c]), .start_tid(start_tid[c]),
      .restart(restart[c]), .vacate(vacate[c]),
      .occ(occ[c]), .tid(tid_v[c]), .full(full[c]),
      .run_sig(run_sig[c]), .cont_sig(cont_flat[c*SIG_W +: SIG_W])
    );
  end

  // lowest full core requests a move; lowest free core takes an arrival
  always_comb begin
    has_full = 1'b0;
    src_c    = '0;
    adm_ok   = 1'b0;
    adm_pick = '0;
    for (int c = N_CORES - 1; c >= 0; c--) begin
      if (full[c]) begin
        has_full = 1'b1;
        src_c    = CORE_W'(c);
      end
      if (!occ[c] && !lock[c]) begin
        adm_ok   = 1'b1;
        adm_pick = CORE_W'(c);
      end
    end
  end

  assign want = run_sig[src_c];

  tmc_dest_pick #(.N_CORES(N_CORES), .CPS(CPS), .SIG_W(SIG_W)) u_pick (
    .src(src_c), .want(want), .cont(cont_flat), .avail(~occ & ~lock),
    .found(d_found), .dst(d_dst)
  );

  assign decide = (st == ST_IDLE) && has_full;
  assign done   = (st == ST_XFER) && (timer == '0);

  always_comb begin
    start      = '0;
    restart    = '0;
    vacate     = '0;
    q_pop      = 1'b0;
    adm_fire   = 1'b0;
    adm_core_c = '0;
    if (decide && !d_found) restart[src_c] = 1'b1;
    if (done) begin
      start[mig_dst] = 1'b1;
      if (!q_empty) begin
        start[mig_src] = 1'b1;
        q_pop          = 1'b1;
        adm_fire       = 1'b1;
        adm_core_c     = mig_src;
      end else begin
        vacate[mig_src] = 1'b1;
      end
    end else if (!decide && !q_empty && adm_ok) begin
      start[adm_pick] = 1'b1;
      q_pop           = 1'b1;
      adm_fire        = 1'b1;
      adm_core_c      = adm_pick;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      timer     <= '0;
      lock_on   <= 1'b0;
      mig_valid <= 1'b0;
      mig_src   <= '0;
      mig_dst   <= '0;
      mig_tid   <= '0;
      adm_valid <= 1'b0;
      adm_core  <= '0;
      adm_tid   <= '0;
    end else begin
      adm_valid <= adm_fire;
      if (adm_fire) begin
        adm_core <= adm_core_c;
        adm_tid  <= q_dout;
      end
      unique case (st)
        ST_IDLE: if (decide && d_found) begin
          mig_valid <= 1'b1;
          mig_src   <= src_c;
          mig_dst   <= d_dst;
          mig_tid   <= tid_v[src_c];
          lock_on   <= 1'b1;
          st        <= ST_REQ;
        end
        ST_REQ: if (mig_ready) begin
          mig_valid <= 1'b0;
          timer     <= TMR_W'(XFER_CYC - 1);
          st        <= ST_XFER;
        end
        ST_XFER: if (timer == '0) begin
          lock_on <= 1'b0;
          st      <= ST_IDLE;
        end else begin
          timer <= timer - 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tmc_migrate_ctl_chk.sv
module tmc_migrate_ctl_chk #(
  parameter int N_CORES  = 4,
  parameter int CPS      = 2,
  parameter int TID_W    = 4,
  parameter int XFER_CYC = 90
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       arr_valid,
  input logic                       arr_ready,
  input logic                       mig_valid,
  input logic                       mig_ready,
  input logic [$clog2(N_CORES)-1:0] mig_src,
  input logic [$clog2(N_CORES)-1:0] mig_dst,
  input logic [TID_W-1:0]           mig_tid,
  input logic                       adm_valid,
  input logic [$clog2(N_CORES)-1:0] adm_core
);
  int win;
  int pend;
  logic [$clog2(N_CORES)-1:0] dst_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      win   <= 0;
      pend  <= 0;
      dst_q <= '0;
    end else begin
      if (mig_valid && mig_ready) begin
        win   <= XFER_CYC;
        dst_q <= mig_dst;
      end else if (win != 0) begin
        win <= win - 1;
      end
      pend <= pend + ((arr_valid && arr_ready) ? 1 : 0) - (adm_valid ? 1 : 0);
    end
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (mig_valid && !mig_ready) |=> (mig_valid && $stable(mig_src) && $stable(mig_dst) && $stable(mig_tid)));

  p_same_socket_r4: assert property (@(posedge clk) disable iff (rst)
    mig_valid |-> ((mig_src != mig_dst) && ((int'(mig_src) / CPS) == (int'(mig_dst) / CPS))));

  p_quiet_window_r8: assert property (@(posedge clk) disable iff (rst)
    (win != 0) |-> !mig_valid);

  p_dst_untouched_r8: assert property (@(posedge clk) disable iff (rst)
    ((win != 0) && adm_valid) |-> (adm_core != dst_q));

  p_adm_has_arrival_r2: assert property (@(posedge clk) disable iff (rst)
    adm_valid |-> (pend > 0));
endmodule

bind tmc_migrate_ctl tmc_migrate_ctl_chk #(
  .N_CORES(N_CORES), .CPS(CPS), .TID_W(TID_W), .XFER_CYC(XFER_CYC)
) chk_i (
  .clk(clk), .rst(rst), .arr_valid(arr_valid), .arr_ready(arr_ready),
  .mig_valid(mig_valid), .mig_ready(mig_ready), .mig_src(mig_src),
  .mig_dst(mig_dst), .mig_tid(mig_tid), .adm_valid(adm_valid), .adm_core(adm_core)
);

// File: tb/tmc_migrate_ctl_tb_top.sv
module tmc_migrate_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NC    = 6;
  localparam int CPS   = 3;
  localparam int TW    = 4;
  localparam int LW    = 26;
  localparam int FILL  = 4;
  localparam int XFER  = 90;
  localparam int CW    = $clog2(NC);

  // {tid, expected core}
  localparam logic [7:0] ADM_VEC [6] = '{8'h10, 8'h21, 8'h32, 8'h43, 8'h54, 8'h65};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic arr_valid = 1'b0;
  logic [TW-1:0] arr_tid = '0;
  logic arr_ready;
  logic [NC-1:0] miss_valid = '0;
  logic [NC*LW-1:0] miss_line = '0;
  logic [NC-1:0] fin = '0;
  logic mig_valid;
  logic mig_ready = 1'b0;
  logic [CW-1:0] mig_src, mig_dst, adm_core;
  logic [TW-1:0] mig_tid, adm_tid;
  logic adm_valid;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tmc_migrate_ctl #(
    .N_CORES(NC), .CPS(CPS), .TID_W(TW), .LINE_W(LW), .SIG_W(16),
    .FILL_LINES(FILL), .XFER_CYC(XFER), .QDEPTH(4)
  ) dut_i (
    .clk(clk), .rst(rst), .arr_valid(arr_valid), .arr_tid(arr_tid), .arr_ready(arr_ready),
    .miss_valid(miss_valid), .miss_line(miss_line), .fin(fin),
    .mig_valid(mig_valid), .mig_ready(mig_ready), .mig_src(mig_src), .mig_dst(mig_dst),
    .mig_tid(mig_tid), .adm_valid(adm_valid), .adm_core(adm_core), .adm_tid(adm_tid)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int tid);
    @(negedge clk);
    arr_valid = 1'b1;
    arr_tid   = TW'(tid);
    @(negedge clk);
    arr_valid = 1'b0;
  endtask

  task automatic miss(input int core, input int line);
    @(negedge clk);
    miss_valid[core] = 1'b1;
    miss_line[core*LW +: LW] = LW'(line);
    @(negedge clk);
    miss_valid = '0;
  endtask

  task automatic finish_core(input int core);
    @(negedge clk);
    fin[core] = 1'b1;
    @(negedge clk);
    fin = '0;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 mig_valid", int'(mig_valid), 0);
    chk("R1 adm_valid", int'(adm_valid), 0);
    chk("R1 arr_ready", int'(arr_ready), 1);

    // R2: admissions from the vector table, one arrival at a time
    for (int i = 0; i < 6; i++) begin
      push(int'(ADM_VEC[i][7:4]));
      chk("R2 adm early", int'(adm_valid), 0);
      @(negedge clk);
      chk("R2 adm_valid", int'(adm_valid), 1);
      chk("R2 adm_core", int'(adm_core), int'(ADM_VEC[i][3:0]));
      chk("R2 adm_tid", int'(adm_tid), int'(ADM_VEC[i][7:4]));
    end

    // preload content signatures, then free cores 1 and 2
    miss(1, 8); miss(1, 9);
    miss(2, 1); miss(2, 2); miss(2, 3);
    finish_core(1);
    finish_core(2);

    // R3/R4: core 0 fills; core 2 overlaps its lines and beats lower-index core 1
    miss(0, 1); miss(0, 2); miss(0, 3);
    @(negedge clk);
    chk("R3 no early request", int'(mig_valid), 0);
    miss(0, 10);
    chk("R3 not same cycle", int'(mig_valid), 0);
    @(negedge clk);
    chk("R3 mig_valid", int'(mig_valid), 1);
    chk("R4 mig_src", int'(mig_src), 0);
    chk("R4 best match dst", int'(mig_dst), 2);
    chk("R4 mig_tid", int'(mig_tid), 1);

    // R9: freed core 1 takes tid 7 while the move is pending
    push(7);
    @(negedge clk);
    chk("R9 adm_valid", int'(adm_valid), 1);
    chk("R9 adm_core", int'(adm_core), 1);
    push(8);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8 locked cores skipped", int'(adm_valid), 0);
    end
    chk("R7 held valid", int'(mig_valid), 1);
    chk("R7 held dst", int'(mig_dst), 2);

    // R8: handshake, then the vacated core goes to tid 8 exactly XFER cycles later
    mig_ready = 1'b1;
    @(negedge clk);
    mig_ready = 1'b0;
    chk("R8 valid drops", int'(mig_valid), 0);
    begin
      int seen = 0;
      for (int k = 0; k < XFER - 1; k++) begin
        if (adm_valid) seen++;
        @(negedge clk);
      end
      if (adm_valid) seen++;
      chk("R8 no admission in window", seen, 0);
    end
    @(negedge clk);
    chk("R8 adm at window end", int'(adm_valid), 1);
    chk("R8 adm_core vacated", int'(adm_core), 0);
    chk("R8 adm_tid", int'(adm_tid), 8);

    // R5: empty cores 4 and 5 tie at zero; lowest wins
    finish_core(4);
    finish_core(5);
    miss(3, 11); miss(3, 12); miss(3, 13); miss(3, 14);
    @(negedge clk);
    chk("R5 mig_valid", int'(mig_valid), 1);
    chk("R5 mig_src", int'(mig_src), 3);
    chk("R5 tie dst", int'(mig_dst), 4);
    chk("R5 mig_tid", int'(mig_tid), 4);
    mig_ready = 1'b1;
    @(negedge clk);
    mig_ready = 1'b0;
    repeat (XFER + 2) @(negedge clk);

    // R6/R4: core 0 fills but its socket is full; cores 3 and 5 are in the other socket
    miss(0, 1); miss(0, 2); miss(0, 3); miss(0, 4);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R6 no candidate", int'(mig_valid), 0);
    end
    miss(0, 5); miss(0, 6); miss(0, 7);
    finish_core(1);
    @(negedge clk);
    chk("R6 count restarted", int'(mig_valid), 0);
    miss(0, 9);
    @(negedge clk);
    chk("R6 request after refill", int'(mig_valid), 1);
    chk("R6 mig_dst", int'(mig_dst), 1);
    chk("R6 mig_tid", int'(mig_tid), 8);

    finished = 1'b1;
    summary();
  end
endmodule